// File: doc/BRIEF.md
# Late-Increment Adder with Absolute Difference and End-Around Modes

This block is a parallel prefix adder whose "+1" is applied after the carry tree has finished. The tree delivers two group terms per bit position: group generate and group not-kill, each taken over all lower bits. A late carry for every bit is then formed from the group generate, ORed with the late increment gated by the group not-kill. This gives a sum plus one at the cost of one gate level and one extra cell per bit. The block does not keep a second adder and does not select between two results.

The same late stage supports three operations. Add mode returns A+B or A+B+1, as chosen by an increment input. Absolute-difference mode feeds the tree with the inverted B, so the tree computes A−B−1. If the tree's carry-out is set, the late increment is applied and the result is A−B. If the carry-out is clear, the sum bits are all inverted and the result is B−A. End-around mode feeds the tree's carry-out back as the late increment, which gives addition modulo 2^W−1.

Operands enter on a valid/ready stream, and results leave on another valid/ready stream one register later. A transfer takes place on a rising clock edge when valid and ready are both high. The producer must hold `in_a`, `in_b`, `in_inc` and `in_mode` stable while `in_valid` is high and `in_ready` is low. The block holds `out_result` and `out_flag` stable while `out_valid` is high and `out_ready` is low. `in_ready` depends only on the output register being free or drained in the same cycle, so back-pressure flows through with no bubble.

Top module: `late_inc_adder`

## Requirements
- R1: With `in_mode`=0 and `in_inc`=0, a result equals (A+B) mod 2^W and `out_flag` is the carry out of bit W−1.
- R2: With `in_mode`=0 and `in_inc`=1, a result equals (A+B+1) mod 2^W and `out_flag` is set exactly when A+B+1 ≥ 2^W.
- R3: With `in_mode`=1, the result is |A−B| and `out_flag` is 1 exactly when A>B; equal operands give result 0 with flag 0, and `in_inc` is ignored.
- R4: With `in_mode`=2, the result is A+B when A+B < 2^W, and A+B−2^W+1 otherwise, with `out_flag` set exactly in the second case. The all-ones word is a legal encoding of zero. `in_inc` is ignored.
- R5: `in_mode`=3 behaves exactly like `in_mode`=0, including the use of `in_inc`.
- R6: An accepted input (`in_valid` and `in_ready` high at a rising edge) appears with `out_valid` high after that same edge. `in_ready` is high whenever `out_ready` is high or `out_valid` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_flag` stay unchanged.
- R8: While `rst_n` is low and after its release, `out_valid` is 0 until the first accepted input.
- R9: If the output is consumed, or is empty, and no new input is accepted at that edge, `out_valid` goes low; no result is produced without an accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| in_inc | input | 1 | Late increment request (add modes only) |
| in_mode | input | 2 | 0 add, 1 absolute difference, 2 end-around mod 2^W−1, 3 add |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_result | output | W | Result word |
| out_flag | output | 1 | Carry-out (add), A>B (absolute difference), wrap taken (end-around) |

## Verification
The assertions assume that the operand inputs and `in_mode` carry known values whenever `in_valid` is high. They also assume that the consumer drives `out_ready` to a known level on every cycle. The reference results inside the checker are formed from the operands sampled at the accepting edge. For this reason the stimulus changes inputs only at the falling edge and never during reset. Operand values are drawn to hit the carry-out boundary in every mode: equal operands, sums of exactly 2^W−1, and all-ones plus an increment. All four mode codes are used both with and without the increment request, so the rule that the increment is ignored in the non-add modes is exercised.

// File: rtl/lia_pkg.sv
package lia_pkg;
  typedef enum logic [1:0] {
    LIA_ADD     = 2'd0,
    LIA_ABSDIFF = 2'd1,
    LIA_MODM1   = 2'd2,
    LIA_ADD_ALT = 2'd3
  } lia_mode_e;

  // Prefix combine of (generate, not-kill): high group over low group.
  function automatic logic [1:0] lia_combine(input logic g_hi, input logic nk_hi,
                                             input logic g_lo, input logic nk_lo);
    return {g_hi | (nk_hi & g_lo), nk_hi & nk_lo};
  endfunction
endpackage

// File: rtl/lia_bit_cells.sv
module lia_bit_cells #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  output logic [W-1:0] gen,
  output logic [W-1:0] notkill,
  output logic [W-1:0] prop
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic b_eff;
    assign b_eff      = b[i] ^ invert_b;
    assign gen[i]     = a[i] & b_eff;
    assign notkill[i] = a[i] | b_eff;
    assign prop[i]    = a[i] ^ b_eff;
  end
endmodule

// File: rtl/lia_prefix_tree.sv
module lia_prefix_tree
  import lia_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] notkill,
  output logic [W-1:0] grp_g,
  output logic [W-1:0] grp_nk
);
  localparam int LEVELS = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] lvl_g  [0:LEVELS];
  logic [W-1:0] lvl_nk [0:LEVELS];

  assign lvl_g[0]  = gen;
  assign lvl_nk[0] = notkill;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int DIST = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_node
      if (i >= DIST) begin : g_cell
        logic [1:0] merged;
        assign merged = lia_combine(lvl_g[l][i], lvl_nk[l][i],
                                    lvl_g[l][i-DIST], lvl_nk[l][i-DIST]);
        assign lvl_g[l+1][i]  = merged[1];
        assign lvl_nk[l+1][i] = merged[0];
      end else begin : g_pass
        assign lvl_g[l+1][i]  = lvl_g[l][i];
        assign lvl_nk[l+1][i] = lvl_nk[l][i];
      end
    end
  end

  assign grp_g  = lvl_g[LEVELS];
  assign grp_nk = lvl_nk[LEVELS];
endmodule

// File: rtl/lia_late_stage.sv
module lia_late_stage
  import lia_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] grp_g,
  input  logic [W-1:0] grp_nk,
  input  logic         inc,
  input  logic [1:0]   mode,
  output logic [W-1:0] result,
  output logic         flag
);
  lia_mode_e    mode_e;
  logic         tree_cout;
  logic         late_inc;
  logic         invert_all;
  logic [W-1:0] early_c;
  logic [W-1:0] late_c;
  logic [W-1:0] sum;

  assign mode_e    = lia_mode_e'(mode);
  assign tree_cout = grp_g[W-1];

  always_comb begin
    unique case (mode_e)
      LIA_ABSDIFF, LIA_MODM1: late_inc = tree_cout;
      default:                late_inc = inc;
    endcase
  end

  assign early_c[0] = 1'b0;
  assign late_c[0]  = late_inc;
  for (genvar i = 1; i < W; i++) begin : g_late
    assign early_c[i] = grp_g[i-1];
    assign late_c[i]  = early_c[i] | (late_inc & grp_nk[i-1]);
  end

  assign sum        = prop ^ late_c;
  assign invert_all = (mode_e == LIA_ABSDIFF) && !tree_cout;
  assign result     = sum ^ {W{invert_all}};

  always_comb begin
    unique case (mode_e)
      LIA_ABSDIFF, LIA_MODM1: flag = tree_cout;
      default:                flag = tree_cout | (inc & grp_nk[W-1]);
    endcase
  end
endmodule

// File: rtl/late_inc_adder.sv
module late_inc_adder
  import lia_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_inc,
  input  logic [1:0]   in_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_flag
);
  logic [W-1:0] gen, notkill, prop;
  logic [W-1:0] grp_g, grp_nk;
  logic [W-1:0] comb_result;
  logic         comb_flag;
  logic         take;

  lia_bit_cells #(.W(W)) u_cells (
    .a        (in_a),
    .b        (in_b),
    .invert_b (lia_mode_e'(in_mode) == LIA_ABSDIFF),
    .gen      (gen),
    .notkill  (notkill),
    .prop     (prop)
  );

  lia_prefix_tree #(.W(W)) u_tree (
    .gen     (gen),
    .notkill (notkill),
    .grp_g   (grp_g),
    .grp_nk  (grp_nk)
  );

  lia_late_stage #(.W(W)) u_late (
    .prop   (prop),
    .grp_g  (grp_g),
    .grp_nk (grp_nk),
    .inc    (in_inc),
    .mode   (in_mode),
    .result (comb_result),
    .flag   (comb_flag)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_result <= comb_result;
      out_flag   <= comb_flag;
    end
  end
endmodule

// File: rtl/lia_checker.sv
module lia_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         in_inc,
  input logic [1:0]   in_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_flag
);
  logic         acc;
  logic [W:0]   ref_add;
  logic [W:0]   ref_plain;
  logic [W-1:0] ref_abs;
  logic [W-1:0] ref_mod;

  assign acc       = in_valid && in_ready;
  assign ref_add   = {1'b0, in_a} + {1'b0, in_b} + {{W{1'b0}}, in_inc};
  assign ref_plain = {1'b0, in_a} + {1'b0, in_b};
  assign ref_abs   = (in_a > in_b) ? (in_a - in_b) : (in_b - in_a);
  assign ref_mod   = ref_plain[W] ? (ref_plain[W-1:0] + 1'b1) : ref_plain[W-1:0];

  p_add_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == 2'd0 && !in_inc |=> {out_flag, out_result} == $past(ref_add));
  p_add_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == 2'd0 && in_inc |=> {out_flag, out_result} == $past(ref_add));
  p_absdiff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == 2'd1 |=> out_result == $past(ref_abs) && out_flag == $past(in_a > in_b));
  p_endaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == 2'd2 |=> out_result == $past(ref_mod) && out_flag == $past(ref_plain[W]));
  p_alt_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mode == 2'd3 |=> {out_flag, out_result} == $past(ref_add));
  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  p_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready || !out_valid) |-> in_ready);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flag));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && (out_ready || !out_valid) |=> !out_valid);
endmodule

bind late_inc_adder lia_checker #(.W(W)) u_lia_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_a       (in_a),
  .in_b       (in_b),
  .in_inc     (in_inc),
  .in_mode    (in_mode),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flag   (out_flag)
);

// File: tb/tb_late_inc_adder.sv
module tb_late_inc_adder;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 32;
  localparam int WS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          b_iv = 1'b0, b_ir, b_ov, b_or = 1'b0, b_inc = 1'b0, b_flag;
  logic [WB-1:0] b_a = '0, b_b = '0, b_res;
  logic [1:0]    b_mode = 2'd0;

  logic          s_iv = 1'b0, s_ir, s_ov, s_or = 1'b0, s_inc = 1'b0, s_flag;
  logic [WS-1:0] s_a = '0, s_b = '0, s_res;
  logic [1:0]    s_mode = 2'd0;

  late_inc_adder #(.W(WB)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir), .in_a(b_a), .in_b(b_b),
    .in_inc(b_inc), .in_mode(b_mode), .out_valid(b_ov), .out_ready(b_or),
    .out_result(b_res), .out_flag(b_flag));

  late_inc_adder #(.W(WS)) dut_w8 (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir), .in_a(s_a), .in_b(s_b),
    .in_inc(s_inc), .in_mode(s_mode), .out_valid(s_ov), .out_ready(s_or),
    .out_result(s_res), .out_flag(s_flag));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [32:0] qb[$];
  string       tb_q[$];
  logic [32:0] qs[$];
  string       ts_q[$];

  function automatic logic [32:0] model(int w, logic [1:0] m, longint unsigned a,
                                        longint unsigned b, bit inc);
    longint unsigned mask = (longint'(1) << w) - 1;
    longint unsigned s;
    longint unsigned r;
    logic f;
    case (m)
      2'd1: begin f = a > b; r = f ? a - b : b - a; end
      2'd2: begin
        s = a + b;
        if (s > mask) begin r = s - mask; f = 1'b1; end
        else begin r = s; f = 1'b0; end
      end
      default: begin s = a + b + inc; r = s & mask; f = (s >> w) != 0; end
    endcase
    return {f, r[31:0]};
  endfunction

  function automatic string rtag(logic [1:0] m, bit inc);
    case (m)
      2'd1:    return "R3";
      2'd2:    return "R4";
      2'd3:    return "R5";
      default: return inc ? "R2" : "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [32:0] act, logic [32:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_b(bit iv, logic [WB-1:0] a, logic [WB-1:0] b, logic [1:0] m,
                        bit inc, bit ordy);
    @(negedge clk);
    b_iv = iv; b_a = a; b_b = b; b_mode = m; b_inc = inc; b_or = ordy;
    #1;
    if (b_ov) begin
      if (qb.size() == 0) check("R9", {b_flag, b_res}, 33'h0);
      else begin
        check(ordy ? tb_q[0] : {tb_q[0], "/R7"}, {b_flag, b_res}, qb[0]);
        if (ordy) begin void'(qb.pop_front()); void'(tb_q.pop_front()); end
      end
    end
    if (b_ov === 1'b0 || ordy) check("R6", {32'd0, b_ir}, 33'd1);
    if (iv && b_ir) begin
      qb.push_back(model(WB, m, a, b, inc));
      tb_q.push_back(rtag(m, inc));
    end
  endtask

  task automatic step_s(bit iv, logic [WS-1:0] a, logic [WS-1:0] b, logic [1:0] m,
                        bit inc, bit ordy);
    @(negedge clk);
    s_iv = iv; s_a = a; s_b = b; s_mode = m; s_inc = inc; s_or = ordy;
    #1;
    if (s_ov) begin
      if (qs.size() == 0) check("R9", {s_flag, 24'd0, s_res}, 33'h0);
      else begin
        check(ordy ? ts_q[0] : {ts_q[0], "/R7"}, {s_flag, 24'd0, s_res}, qs[0]);
        if (ordy) begin void'(qs.pop_front()); void'(ts_q.pop_front()); end
      end
    end
    if (iv && s_ir) begin
      qs.push_back(model(WS, m, a, b, inc));
      ts_q.push_back(rtag(m, inc));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", {31'd0, b_ov, s_ov}, 33'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8", {31'd0, b_ov, s_ov}, 33'd0);
    check("R6", {31'd0, b_ir, s_ir}, 33'd3);

    // W=8: every operand pair, modes and increment spread over the index
    for (int idx = 0; idx < 65536; idx++) begin
      step_s(1'b1, idx[7:0], idx[15:8], idx[1:0] ^ idx[9:8], idx[2] ^ idx[11], 1'b1);
    end
    for (int k = 0; k < 3; k++) step_s(1'b0, '0, '0, 2'd0, 1'b0, 1'b1);
    check("R9", {32'd0, s_ov}, 33'd0);

    // W=32 directed boundaries
    step_b(1, 32'hFFFF_FFFF, 32'h0, 2'd0, 1, 1);          // R2 all-ones + inc
    step_b(1, 32'hFFFF_FFFF, 32'h1, 2'd0, 0, 1);          // R1 carry out
    step_b(1, 32'h1234_5678, 32'h1234_5678, 2'd1, 1, 1);  // R3 equal
    step_b(1, 32'h0, 32'hFFFF_FFFF, 2'd1, 0, 1);          // R3 B>A
    step_b(1, 32'h8000_0000, 32'h7FFF_FFFF, 2'd1, 0, 1);  // R3 A>B
    step_b(1, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'd2, 1, 1);  // R4 all-ones zero
    step_b(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 0, 1);  // R4 wrap
    step_b(1, 32'hFFFF_FFFF, 32'h0, 2'd3, 1, 1);          // R5
    step_b(1, 32'h0000_0005, 32'h0000_0003, 2'd3, 0, 0);  // R7 stall
    step_b(0, 32'h0, 32'h0, 2'd0, 0, 0);
    step_b(0, 32'h0, 32'h0, 2'd0, 0, 1);

    // W=32 random with back-pressure and idle cycles
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = ($urandom % 8 == 0) ? ra : 32'($urandom);
      if ($urandom % 8 == 1) rb = ~ra;
      step_b(($urandom % 4) != 0, ra, rb, 2'($urandom), 1'($urandom), ($urandom % 4) != 0);
    end
    for (int k = 0; k < 3; k++) step_b(1'b0, '0, '0, 2'd0, 1'b0, 1'b1);
    check("R9", {32'd0, b_ov}, 33'd0);
    check("R9", 33'(qb.size()), 33'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule